// File: doc/BRIEF.md
# Multi-range ADC acquisition interface

This block sits between a host register bus and an external eight-channel, 12-bit successive-approximation converter. The host writes a control byte that names a channel and one of four input ranges. If the converter is idle and the byte is well formed, the block issues a one-cycle start pulse with that channel and range, and reports busy in a status register. It then waits for the converter's done strobe and captures the 12-bit sample.

The captured sample is widened to a 16-bit result word. Unipolar ranges fill the top four bits with zeros. Bipolar ranges copy the sample's sign bit into them. The polarity comes from the range bits held at start, so a later control write cannot change the format of a pending result.

The host reads the result as one word at the data address, or as two bytes. A completion watchdog, sized in clock cycles, ends a conversion that never finishes and raises a fault flag, so the block never stays busy forever. Control writes made during a conversion are dropped and recorded in a sticky overrun flag.

Top module: `adc_acq_ctrl`

## Requirements
- R1: A control write (bus_addr = 2) made while idle, with control bits 7..5 all zero, produces a single-cycle cnv_start in the following cycle. cnv_chan carries control bits 2..0 and cnv_range carries control bits 4..3. Status bit 0 (busy) reads 1 from then on.
- R2: Busy stays 1 until cnv_done is seen high while busy. cnv_data is captured in that cycle and busy returns to 0.
- R3: When control bit 3 was 0 at start (unipolar ranges 0 and 2), result bits 15..12 are zero and bits 11..0 equal the captured sample.
- R4: When control bit 3 was 1 at start (bipolar ranges 1 and 3), result bits 15..12 equal sample bit 11 and bits 11..0 equal the sample.
- R5: A read is registered. bus_rdata shows the selected value in the cycle after bus_rd. Address 0 returns the 16-bit result, and its bits 7..0 serve as the low byte. Address 1 returns the result's high byte in bits 7..0, with zeros above. Address 2 returns status in bits 3..0: bit 0 busy, bit 1 overrun, bit 2 fault, bit 3 bad request. Address 3 returns zero.
- R6: An idle control write with any of bits 7..5 set starts nothing and sets status bit 3. The next accepted start clears it.
- R7: A control write made while busy is ignored, with no start and no change to channel, range or format. It sets status bit 1, which a status read clears; a set in the same cycle as the read wins.
- R8: The polarity chosen at start governs the result even if a control write of another range arrives before completion.
- R9: If TIMEOUT_CYC busy cycles pass without cnv_done, busy returns to 0, status bit 2 is set and the previous result is kept. The next accepted start clears bit 2.
- R10: cnv_done while idle has no effect on the result.
- R11: After reset, the status, the result, cnv_start and bus_rdata are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Host write strobe |
| bus_rd | input | 1 | Host read strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data (control byte) |
| bus_rdata | output | 16 | Registered read data |
| cnv_start | output | 1 | Start pulse to the converter |
| cnv_chan | output | 3 | Channel held for the conversion |
| cnv_range | output | 2 | Range held for the conversion |
| cnv_done | input | 1 | Converter completion strobe |
| cnv_data | input | 12 | Converter sample, valid with cnv_done |

## Verification
The assertions assume that cnv_done is a clean, synchronous strobe and that cnv_data is valid in the cycle it is high. They also assume that the host drives bus_wr and bus_rd as single-cycle strobes.

The bench's converter model answers each start with exactly one done pulse, a fixed number of cycles later. It can be silenced to provoke the watchdog. One separate directed pulse exercises a done strobe that arrives while the block is idle. Host strobes are driven one cycle at a time on the falling edge, so the sticky-flag and overrun cases stay within these assumptions.

// File: rtl/adc_acq_pkg.sv
package adc_acq_pkg;
  localparam int BYTE_W = 8;
  localparam logic [1:0] ADDR_DATA    = 2'd0;
  localparam logic [1:0] ADDR_DATA_HI = 2'd1;
  localparam logic [1:0] ADDR_CTRL    = 2'd2;
  localparam int ST_BUSY   = 0;
  localparam int ST_OVR    = 1;
  localparam int ST_FAULT  = 2;
  localparam int ST_BADREQ = 3;
endpackage

// File: rtl/adc_seq.sv
module adc_seq #(
  parameter int CTRL_W      = 8,
  parameter int CH_W        = 3,
  parameter int RG_W        = 2,
  parameter int TIMEOUT_CYC = 5000000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_ctrl,
  input  logic [CTRL_W-1:0] ctrl,
  input  logic              cnv_done,
  output logic              busy,
  output logic              cnv_start,
  output logic [CH_W-1:0]   cnv_chan,
  output logic [RG_W-1:0]   cnv_range,
  output logic              bipolar,
  output logic              accept,
  output logic              ovr_set,
  output logic              bad_set,
  output logic              done_hit,
  output logic              to_hit
);
  localparam int FLD_W = CH_W + RG_W;
  localparam int TMR_W = $clog2(TIMEOUT_CYC + 1);
  localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(TIMEOUT_CYC - 1);

  logic [TMR_W-1:0] timer_q;
  logic             rsvd_bad;

  always_comb begin
    rsvd_bad = |ctrl[CTRL_W-1:FLD_W];
    accept   = wr_ctrl && !busy && !rsvd_bad;
    bad_set  = wr_ctrl && !busy && rsvd_bad;
    ovr_set  = wr_ctrl && busy;
    done_hit = busy && cnv_done;
    to_hit   = busy && !cnv_done && (timer_q == TMR_LAST);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      cnv_start <= 1'b0;
      cnv_chan  <= '0;
      cnv_range <= '0;
      bipolar   <= 1'b0;
      timer_q   <= '0;
    end else begin
      cnv_start <= accept;
      if (accept) begin
        busy      <= 1'b1;
        cnv_chan  <= ctrl[CH_W-1:0];
        cnv_range <= ctrl[FLD_W-1:CH_W];
        bipolar   <= ctrl[CH_W];
        timer_q   <= '0;
      end else if (done_hit || to_hit) begin
        busy <= 1'b0;
      end else if (busy) begin
        timer_q <= timer_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/adc_fmt.sv
module adc_fmt #(
  parameter int DATA_W = 12,
  parameter int OUT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              capture,
  input  logic              bipolar,
  input  logic [DATA_W-1:0] raw,
  output logic [OUT_W-1:0]  result
);
  localparam int EXT_W = OUT_W - DATA_W;

  logic [OUT_W-1:0] formatted;

  generate
    if (EXT_W > 0) begin : g_ext
      logic [EXT_W-1:0] ext;
      always_comb begin
        ext       = bipolar ? {EXT_W{raw[DATA_W-1]}} : '0;
        formatted = {ext, raw};
      end
    end else begin : g_trunc
      always_comb formatted = raw[DATA_W-1 -: OUT_W];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)          result <= '0;
    else if (capture) result <= formatted;
  end
endmodule

// File: rtl/adc_flags.sv
module adc_flags (
  input  logic clk,
  input  logic rst,
  input  logic accept,
  input  logic ovr_set,
  input  logic bad_set,
  input  logic to_hit,
  input  logic stat_rd,
  output logic ovr,
  output logic fault,
  output logic bad
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ovr   <= 1'b0;
      fault <= 1'b0;
      bad   <= 1'b0;
    end else begin
      if (ovr_set)      ovr <= 1'b1;
      else if (stat_rd) ovr <= 1'b0;
      if (to_hit)       fault <= 1'b1;
      else if (accept)  fault <= 1'b0;
      if (bad_set)      bad <= 1'b1;
      else if (accept)  bad <= 1'b0;
    end
  end
endmodule

// File: rtl/adc_acq_ctrl.sv
module adc_acq_ctrl
  import adc_acq_pkg::*;
#(
  parameter int CH_W        = 3,
  parameter int RG_W        = 2,
  parameter int DATA_W      = 12,
  parameter int OUT_W       = 16,
  parameter int ADDR_W      = 2,
  parameter int TIMEOUT_CYC = 5000000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [OUT_W-1:0]  bus_rdata,
  output logic              cnv_start,
  output logic [CH_W-1:0]   cnv_chan,
  output logic [RG_W-1:0]   cnv_range,
  input  logic              cnv_done,
  input  logic [DATA_W-1:0] cnv_data
);
  logic wr_ctrl, stat_rd;
  logic busy, bipolar, accept, ovr_set, bad_set, done_hit, to_hit;
  logic ovr, fault, bad;
  logic [OUT_W-1:0]  result;
  logic [BYTE_W-1:0] status;

  always_comb begin
    wr_ctrl = bus_wr && (bus_addr == ADDR_W'(ADDR_CTRL));
    stat_rd = bus_rd && (bus_addr == ADDR_W'(ADDR_CTRL));
    status  = '0;
    status[ST_BUSY]   = busy;
    status[ST_OVR]    = ovr;
    status[ST_FAULT]  = fault;
    status[ST_BADREQ] = bad;
  end

  adc_seq #(
    .CTRL_W(BYTE_W), .CH_W(CH_W), .RG_W(RG_W), .TIMEOUT_CYC(TIMEOUT_CYC)
  ) u_seq (
    .clk(clk), .rst(rst), .wr_ctrl(wr_ctrl), .ctrl(bus_wdata), .cnv_done(cnv_done),
    .busy(busy), .cnv_start(cnv_start), .cnv_chan(cnv_chan), .cnv_range(cnv_range),
    .bipolar(bipolar), .accept(accept), .ovr_set(ovr_set), .bad_set(bad_set),
    .done_hit(done_hit), .to_hit(to_hit)
  );

  adc_fmt #(.DATA_W(DATA_W), .OUT_W(OUT_W)) u_fmt (
    .clk(clk), .rst(rst), .capture(done_hit), .bipolar(bipolar),
    .raw(cnv_data), .result(result)
  );

  adc_flags u_flags (
    .clk(clk), .rst(rst), .accept(accept), .ovr_set(ovr_set), .bad_set(bad_set),
    .to_hit(to_hit), .stat_rd(stat_rd), .ovr(ovr), .fault(fault), .bad(bad)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      case (bus_addr)
        ADDR_W'(ADDR_DATA):    bus_rdata <= result;
        ADDR_W'(ADDR_DATA_HI): bus_rdata <= OUT_W'(result[OUT_W-1:BYTE_W]);
        ADDR_W'(ADDR_CTRL):    bus_rdata <= OUT_W'(status);
        default:               bus_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/adc_acq_ctrl_chk.sv
module adc_acq_ctrl_chk
  import adc_acq_pkg::*;
#(
  parameter int CH_W   = 3,
  parameter int RG_W   = 2,
  parameter int DATA_W = 12,
  parameter int OUT_W  = 16,
  parameter int ADDR_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [BYTE_W-1:0] bus_wdata,
  input logic              cnv_start,
  input logic              cnv_done,
  input logic              busy,
  input logic              fault,
  input logic [OUT_W-1:0]  result
);
  localparam int FLD_W = CH_W + RG_W;
  localparam int EXT_W = OUT_W - DATA_W;

  logic wr_c, wr_bad;
  always_comb begin
    wr_c   = bus_wr && (bus_addr == ADDR_W'(ADDR_CTRL));
    wr_bad = wr_c && (|bus_wdata[BYTE_W-1:FLD_W]);
  end

  a_r1_start_one_cycle: assert property (@(posedge clk) disable iff (rst)
    cnv_start |=> !cnv_start);
  a_r1_start_with_busy: assert property (@(posedge clk) disable iff (rst)
    cnv_start |-> busy);
  a_r2_busy_ends_by_done_or_fault: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> ($past(cnv_done) || fault));
  a_r7_no_start_when_busy: assert property (@(posedge clk) disable iff (rst)
    (wr_c && busy) |=> !cnv_start);
  a_r6_no_start_on_bad: assert property (@(posedge clk) disable iff (rst)
    wr_bad |=> !cnv_start);
  a_r3_r4_ext_shape: assert property (@(posedge clk) disable iff (rst)
    (result[OUT_W-1:DATA_W] == '0) ||
    ((result[OUT_W-1:DATA_W] == {EXT_W{1'b1}}) && result[DATA_W-1]));
  a_r10_idle_done_ignored: assert property (@(posedge clk) disable iff (rst)
    (!busy && cnv_done) |=> $stable(result));
  a_r9_fault_leaves_idle: assert property (@(posedge clk) disable iff (rst)
    $rose(fault) |-> !busy);
endmodule

bind adc_acq_ctrl adc_acq_ctrl_chk #(
  .CH_W(CH_W), .RG_W(RG_W), .DATA_W(DATA_W), .OUT_W(OUT_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .cnv_start(cnv_start), .cnv_done(cnv_done), .busy(busy), .fault(fault),
  .result(result)
);

// File: tb/adc_acq_ctrl_tb.sv
`timescale 1ns/1ps
module adc_acq_ctrl_tb;
  localparam int TO_CYC = 40;
  localparam int DELAY  = 6;
  localparam int NVEC   = 6;
  // {ctrl[7:0], sample[11:0], expected word[15:0]}
  localparam logic [35:0] VEC [NVEC] = '{
    {8'h05, 12'hABC, 16'h0ABC},
    {8'h0A, 12'h800, 16'hF800},
    {8'h08, 12'h7FF, 16'h07FF},
    {8'h17, 12'hFFF, 16'h0FFF},
    {8'h01, 12'h000, 16'h0000},
    {8'h1B, 12'h9A5, 16'hF9A5}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        cnv_start;
  logic [2:0]  cnv_chan;
  logic [1:0]  cnv_range;
  logic        cnv_done;
  logic [11:0] cnv_data;

  logic        mdl_en = 1'b1;
  logic        mdl_done;
  logic        spur_done = 1'b0;
  logic [11:0] mdl_data = '0;
  int          mdl_cnt;
  int          n_start;
  logic [2:0]  cap_ch;
  logic [1:0]  cap_rg;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  assign cnv_done = mdl_done | spur_done;
  assign cnv_data = mdl_data;

  adc_acq_ctrl #(.TIMEOUT_CYC(TO_CYC)) u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cnv_start(cnv_start),
    .cnv_chan(cnv_chan), .cnv_range(cnv_range), .cnv_done(cnv_done), .cnv_data(cnv_data)
  );

  // behavioural converter
  always @(posedge clk) begin
    if (rst) begin
      mdl_done <= 1'b0; mdl_cnt <= 0; n_start <= 0; cap_ch <= '0; cap_rg <= '0;
    end else begin
      mdl_done <= 1'b0;
      if (cnv_start) begin
        n_start <= n_start + 1;
        cap_ch  <= cnv_chan;
        cap_rg  <= cnv_range;
        if (mdl_en) mdl_cnt <= DELAY;
      end else if (mdl_cnt != 0) begin
        mdl_cnt <= mdl_cnt - 1;
        if (mdl_cnt == 1) mdl_done <= 1'b1;
      end
    end
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [15:0] v);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; v = bus_rdata;
  endtask

  task automatic wait_idle();
    logic [15:0] s;
    for (int i = 0; i < 200; i++) begin
      bus_read(2'd2, s);
      if (s[0] == 1'b0) break;
    end
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] v;
    int ns;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R11 reset state
    chk("R11 cnv_start", {15'd0, cnv_start}, 16'h0000);
    chk("R11 rdata", bus_rdata, 16'h0000);
    bus_read(2'd2, v); chk("R11 status", v, 16'h0000);
    bus_read(2'd0, v); chk("R11 result", v, 16'h0000);
    bus_read(2'd3, v); chk("R5 unused addr", v, 16'h0000);

    // vector loop: R1 R2 R3 R4 R5
    for (int k = 0; k < NVEC; k++) begin
      logic [7:0]  c;
      logic [15:0] e;
      c = VEC[k][35:28]; e = VEC[k][15:0];
      mdl_data = VEC[k][27:16];
      ns = n_start;
      bus_write(2'd2, c);
      bus_read(2'd2, v); chk("R1 busy after start", v & 16'h0001, 16'h0001);
      wait_idle();
      chk("R1 one start", 16'(n_start - ns), 16'h0001);
      chk("R1 channel", {13'd0, cap_ch}, {13'd0, c[2:0]});
      chk("R1 range", {14'd0, cap_rg}, {14'd0, c[4:3]});
      bus_read(2'd2, v); chk("R2 idle status", v, 16'h0000);
      bus_read(2'd0, v); chk(c[3] ? "R4 word" : "R3 word", v, e);
      chk("R5 low byte", {8'd0, v[7:0]}, {8'd0, e[7:0]});
      bus_read(2'd1, v); chk("R5 high byte", v, {8'd0, e[15:8]});
    end

    // R10 done while idle
    mdl_data = 12'h123;
    @(negedge clk); spur_done = 1'b1;
    @(negedge clk); spur_done = 1'b0;
    bus_read(2'd0, v); chk("R10 idle done ignored", v, 16'hF9A5);

    // R6 bad request
    ns = n_start;
    bus_write(2'd2, 8'h25);
    repeat (3) @(negedge clk);
    bus_read(2'd2, v); chk("R6 bad flag", v, 16'h0008);
    chk("R6 no start", 16'(n_start - ns), 16'h0000);
    bus_write(2'd2, 8'h80);
    bus_read(2'd2, v); chk("R6 bit7 bad", v, 16'h0008);

    // R7 / R8 overrun and latched polarity
    ns = n_start;
    mdl_data = 12'h800;
    bus_write(2'd2, 8'h08);
    bus_write(2'd2, 8'h00);
    bus_read(2'd2, v); chk("R7 overrun busy (R6 cleared)", v, 16'h0003);
    bus_read(2'd2, v); chk("R7 overrun cleared by read", v, 16'h0001);
    wait_idle();
    chk("R7 ignored write no start", 16'(n_start - ns), 16'h0001);
    chk("R7 channel kept", {13'd0, cap_ch}, 16'h0000);
    bus_read(2'd0, v); chk("R8 polarity latched", v, 16'hF800);

    // R9 timeout
    ns = n_start;
    mdl_en = 1'b0;
    bus_write(2'd2, 8'h03);
    repeat (TO_CYC - 4) @(negedge clk);
    bus_read(2'd2, v); chk("R9 still busy before limit", v, 16'h0001);
    repeat (10) @(negedge clk);
    bus_read(2'd2, v); chk("R9 fault flag", v, 16'h0004);
    bus_read(2'd0, v); chk("R9 result kept", v, 16'hF800);

    // R9 recovery
    mdl_en = 1'b1;
    mdl_data = 12'h456;
    bus_write(2'd2, 8'h02);
    wait_idle();
    bus_read(2'd2, v); chk("R9 fault cleared", v, 16'h0000);
    bus_read(2'd0, v); chk("R3 after recovery", v, 16'h0456);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule